// File: doc/BRIEF.md
# Widening Half-Vector Lane Multiplier

This block multiplies the packed integer lanes of two 128-bit vectors, using only half of the source lanes. A half-select control picks either the lower 64 bits or the upper 64 bits of both operands. Each selected lane of operand A is multiplied by the lane in the same position of operand B. Every product is kept at its full width, which is twice the source lane width, so the products together fill a 128-bit result.

Source lanes can be 8, 16 or 32 bits wide. A signedness control picks how operands are extended before the multiply: two's-complement sign extension or zero extension. The block has one register stage. An input valid strobe is delayed along with the result. All controls are sampled on the same clock edge as the operands.

Top module: `wide_half_mul`

## Requirements
- R1: With `lane_size`=00 (8-bit lanes), the block multiplies bytes j=0..7 of the selected half. Byte j is bits 8j+7:8j of that half. The 16-bit product goes to `result[16j+15:16j]`.
- R2: With `lane_size`=01 (16-bit lanes), the block multiplies halfwords j=0..3 of the selected half. The 32-bit product goes to `result[32j+31:32j]`.
- R3: With `lane_size`=10 (32-bit lanes), the block multiplies words j=0..1 of the selected half. The 64-bit product goes to `result[64j+63:64j]`.
- R4: With `upper`=0 the selected half is bits 63:0 of each operand. With `upper`=1 it is bits 127:64 of each operand.
- R5: With `is_signed`=1, lanes are read as two's complement and the product is exact. For example, -128 × -128 on 8-bit lanes gives 0x4000, and 0x80000000 squared on 32-bit lanes gives 0x4000000000000000.
- R6: With `is_signed`=0, lanes are zero-extended. For example, 255 × 255 on 8-bit lanes gives 0xFE01, and 0xFFFFFFFF squared gives 0xFFFFFFFE00000001.
- R7: `lane_size`=11 is reserved. An accepted operation with this code produces an all-zero result.
- R8: An operation presented with `in_valid`=1 on a rising clock edge appears on `result`, with `out_valid`=1, right after that edge. `out_valid` is low after any edge where `in_valid` was low.
- R9: While `in_valid` is low, `result` keeps its previous value, whatever the operands and controls do.
- R10: While `rst_n` is low, `out_valid` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| lane_size | input | 2 | Source lane width: 00=8, 01=16, 10=32, 11=reserved |
| upper | input | 1 | 0 selects the lower half of the lanes, 1 selects the upper half |
| is_signed | input | 1 | 1 for two's-complement lanes, 0 for unsigned lanes |
| op_a | input | 128 | First operand vector |
| op_b | input | 128 | Second operand vector |
| out_valid | output | 1 | Result is valid |
| result | output | 128 | Packed double-width products |

## Verification
The bench drives the most negative lane value squared. If the operands were truncated to the lane width, or the product to the source width, the result would have the wrong sign or lose the upper bits. The bench also multiplies all-ones lanes in unsigned mode, where a design that sign-extended by mistake would return 1 instead of the large product. The two halves of each operand hold different lane values, so swapping the low and high selects, or reversing the lane order, gives a visibly wrong pattern. The bench also changes operands while `in_valid` is low and checks that `result` does not move, and it checks that the reserved size code gives zero.

// File: rtl/wide_half_mul.sv
module wide_half_mul #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       lane_size,
  input  logic             upper,
  input  logic             is_signed,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);
  localparam int HALF_W = VEC_W / 2;
  localparam int N8     = HALF_W / 8;
  localparam int N16    = HALF_W / 16;
  localparam int N32    = HALF_W / 32;

  logic [HALF_W-1:0] ha, hb;
  logic [VEC_W-1:0]  r8, r16, r32, nxt;

  assign ha = upper ? op_a[VEC_W-1:HALF_W] : op_a[HALF_W-1:0];
  assign hb = upper ? op_b[VEC_W-1:HALF_W] : op_b[HALF_W-1:0];

  for (genvar i = 0; i < N8; i++) begin : g_b8
    logic signed [15:0] ea, eb;
    assign ea = {{8{is_signed & ha[8*i+7]}}, ha[8*i +: 8]};
    assign eb = {{8{is_signed & hb[8*i+7]}}, hb[8*i +: 8]};
    assign r8[16*i +: 16] = ea * eb;
  end

  for (genvar i = 0; i < N16; i++) begin : g_b16
    logic signed [31:0] ea, eb;
    assign ea = {{16{is_signed & ha[16*i+15]}}, ha[16*i +: 16]};
    assign eb = {{16{is_signed & hb[16*i+15]}}, hb[16*i +: 16]};
    assign r16[32*i +: 32] = ea * eb;
  end

  for (genvar i = 0; i < N32; i++) begin : g_b32
    logic signed [63:0] ea, eb;
    assign ea = {{32{is_signed & ha[32*i+31]}}, ha[32*i +: 32]};
    assign eb = {{32{is_signed & hb[32*i+31]}}, hb[32*i +: 32]};
    assign r32[64*i +: 64] = ea * eb;
  end

  always_comb begin
    case (lane_size)
      2'b00:   nxt = r8;
      2'b01:   nxt = r16;
      2'b10:   nxt = r32;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

module wide_half_mul_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       lane_size,
  input logic             upper,
  input logic [VEC_W-1:0] op_a,
  input logic             out_valid,
  input logic [VEC_W-1:0] result
);
  localparam int HALF_W = VEC_W / 2;
  logic a_half_zero;
  assign a_half_zero = upper ? (op_a[VEC_W-1:HALF_W] == '0) : (op_a[HALF_W-1:0] == '0);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R8
  AST_VALID_DROPS:   assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R8
  AST_RESULT_HOLDS:  assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result)); // R9
  AST_RSVD_ZERO:     assert property (@(posedge clk) disable iff (!rst_n) (in_valid && lane_size == 2'b11) |=> result == '0); // R7
  AST_ZERO_OPERAND:  assert property (@(posedge clk) disable iff (!rst_n) (in_valid && a_half_zero) |=> result == '0); // R4
endmodule

bind wide_half_mul wide_half_mul_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_size(lane_size),
  .upper(upper), .op_a(op_a), .out_valid(out_valid), .result(result)
);

// File: tb/wide_half_mul_bench.sv
module wide_half_mul_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   lane_size = 2'b00;
  logic         upper = 1'b0;
  logic         is_signed = 1'b0;
  logic [127:0] op_a = '0, op_b = '0;
  logic         out_valid;
  logic [127:0] result;
  int           errors = 0, checks = 0;

  always #4 clk = ~clk;

  wide_half_mul u_wide_half_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_size(lane_size),
    .upper(upper), .is_signed(is_signed), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic signed [131:0] lane_val(logic [127:0] v, int pos, int w, logic sg);
    logic signed [131:0] x;
    x = 132'(v >> pos) & ((132'sd1 <<< w) - 1);
    if (sg && x[w-1]) x = x - (132'sd1 <<< w);
    return x;
  endfunction

  function automatic logic [127:0] model(logic [127:0] a, logic [127:0] b,
                                         logic [1:0] sz, logic hi, logic sg);
    logic [127:0] r = '0;
    int w, n;
    logic signed [131:0] p;
    if (sz == 2'b11) return '0;
    w = 8 << sz;
    n = 64 / w;
    for (int j = 0; j < n; j++) begin
      p = lane_val(a, (hi ? 64 : 0) + j*w, w, sg) * lane_val(b, (hi ? 64 : 0) + j*w, w, sg);
      for (int k = 0; k < 2*w; k++) r[2*w*j + k] = p[k];
    end
    return r;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [127:0] a, logic [127:0] b, logic [1:0] sz, logic hi, logic sg);
    @(negedge clk);
    op_a = a; op_b = b; lane_size = sz; upper = hi; is_signed = sg; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(string req, logic [127:0] a, logic [127:0] b, logic [1:0] sz, logic hi, logic sg);
    issue(a, b, sz, hi, sg);
    check({req, " valid"}, 128'(out_valid), 128'd1);
    check(req, result, model(a, b, sz, hi, sg));
  endtask

  task automatic t_reset;
    check("R10 valid", 128'(out_valid), 128'd0);
    check("R10 result", result, '0);
  endtask

  localparam logic [127:0] PA = 128'h8877665544332211_F0E1D2C3B4A59687;
  localparam logic [127:0] PB = 128'h0F1E2D3C4B5A6978_7F80FF0102037E81;

  task automatic t_bytes;
    run("R1 low unsigned", PA, PB, 2'b00, 1'b0, 1'b0);
    run("R1 R4 high signed", PA, PB, 2'b00, 1'b1, 1'b1);
  endtask

  task automatic t_halves;
    run("R2 low signed", PA, PB, 2'b01, 1'b0, 1'b1);
    run("R2 R4 high unsigned", PA, PB, 2'b01, 1'b1, 1'b0);
  endtask

  task automatic t_words;
    run("R3 low unsigned", PA, PB, 2'b10, 1'b0, 1'b0);
    run("R3 R4 high signed", PA, PB, 2'b10, 1'b1, 1'b1);
  endtask

  task automatic t_signed_edges;
    issue({64'h0, {8{8'h80}}}, {64'h0, {8{8'h80}}}, 2'b00, 1'b0, 1'b1);
    check("R5 byte -128^2", result, {8{16'h4000}});
    issue({{2{32'h80000000}}, 64'h0}, {{2{32'h80000000}}, 64'h0}, 2'b10, 1'b1, 1'b1);
    check("R5 word min^2", result, {2{64'h4000000000000000}});
    issue({64'h0, {4{16'hFFFF}}}, {64'h0, {4{16'h0003}}}, 2'b01, 1'b0, 1'b1);
    check("R5 half -1*3", result, {4{32'hFFFFFFFD}});
  endtask

  task automatic t_unsigned_edges;
    issue({{8{8'hFF}}, 64'h0}, {{8{8'hFF}}, 64'h0}, 2'b00, 1'b1, 1'b0);
    check("R6 byte 255^2", result, {8{16'hFE01}});
    issue({64'h0, {2{32'hFFFFFFFF}}}, {64'h0, {2{32'hFFFFFFFF}}}, 2'b10, 1'b0, 1'b0);
    check("R6 word max^2", result, {2{64'hFFFFFFFE00000001}});
  endtask

  task automatic t_reserved;
    issue(PA, PB, 2'b11, 1'b0, 1'b1);
    check("R7 reserved", result, '0);
  endtask

  task automatic t_hold;
    logic [127:0] exp;
    issue(PA, PB, 2'b00, 1'b0, 1'b0);
    exp = model(PA, PB, 2'b00, 1'b0, 1'b0);
    check("R8 result", result, exp);
    op_a = ~PA; op_b = ~PB; lane_size = 2'b01; upper = 1'b1; is_signed = 1'b1;
    @(negedge clk);
    check("R8 valid low", 128'(out_valid), 128'd0);
    check("R9 hold", result, exp);
    @(negedge clk);
    check("R9 hold 2", result, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_bytes;
    t_halves;
    t_words;
    t_signed_edges;
    t_unsigned_edges;
    t_reserved;
    t_hold;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule